// File: doc/BRIEF.md
# Receive Frame Group Classifier

This block assigns a software group code to each received 802.11 MPDU. A parser upstream presents the frame control field and a few frame attributes, with a one-cycle input strobe: whether the receiver address is a group address, whether the PPDU was a null data packet, whether the PHY flagged an error, and whether the frame arrived in a trigger-based or uplink multi-user PPDU. The block picks a code between 0 and 39 and registers it. The code appears with an output strobe one clock after the input strobe.

Software uses the code to steer frames into processing queues. Management and control frames are spread over sixteen codes each, indexed by subtype. QoS Null frames get their own pair of codes, split by trigger-based reception. PHY errors, null data packets and frames that cannot be parsed each get a dedicated code. Rules are tried in a fixed priority order, and the first rule that matches sets the code.

Top module: `rx_frame_grouper`

## Requirements
- R1: `grp_valid` is high exactly in the cycle after a cycle in which `hdr_valid` was sampled high. A synchronous active-low reset drives `grp_valid` and `grp_code` to 0.
- R2: Frame control bits [1:0] are the protocol version, bits [3:2] the type (0 management, 1 control, 2 data, 3 reserved) and bits [7:4] the subtype. Bits [15:8] have no effect on the code.
- R3: When `phy_err` is high the code is 37, whatever the other inputs are.
- R4: When `ndp` is high and `phy_err` is low the code is 0.
- R5: With neither `phy_err` nor `ndp` high, a protocol version other than 0 or a type of 3 gives code 36.
- R6: A management frame gets code 4 plus its subtype (4 to 19).
- R7: A control frame gets code 20 plus its subtype (20 to 35).
- R8: A data frame with subtype 4 (Null) gets code 3.
- R9: A data frame with subtype 12 (QoS Null) gets code 38, or code 39 when `tb_ppdu` is high.
- R10: Any other data frame gets code 1 when `ra_group` is high and code 2 when it is low. `tb_ppdu` has no effect on these codes.
- R11: `grp_code` keeps its value in cycles after which `hdr_valid` was low. While `grp_valid` is high, the code never exceeds 39.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hdr_valid | input | 1 | Input strobe, one frame per high cycle |
| frame_ctl | input | 16 | 802.11 frame control field |
| ra_group | input | 1 | Receiver address group/individual bit |
| ndp | input | 1 | Frame is a null data packet |
| phy_err | input | 1 | PHY reported an error for this PPDU |
| tb_ppdu | input | 1 | Frame arrived in a trigger-based or uplink multi-user PPDU |
| grp_valid | output | 1 | Output strobe, one cycle after `hdr_valid` |
| grp_code | output | 7 | Frame group code, 0 to 39 |

## Verification
Several vectors set more than one rule's condition at once, to show which rule wins:
- PHY error together with NDP.
- NDP together with a reserved type.
- A nonzero protocol version on a Null subtype.

Subtypes 0, 15 and a middle value are used for both management and control frames. These show that the subtype offset is added rather than clipped.

Data frames are tried with:
- Both states of the group bit.
- `tb_ppdu` high on both QoS Null and plain data.
- Upper frame control bits set.

These separate the QoS Null split from the multicast and unicast decision. They also show that flag bits outside the low byte are ignored. Idle cycles and a mid-stream reset check that the registered code holds and clears.

// File: rtl/rx_frame_grouper.sv
module rx_frame_grouper #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [15:0]       frame_ctl,
  input  logic              ra_group,
  input  logic              ndp,
  input  logic              phy_err,
  input  logic              tb_ppdu,
  output logic              grp_valid,
  output logic [CODE_W-1:0] grp_code
);
  localparam logic [CODE_W-1:0] C_NDP     = CODE_W'(0);
  localparam logic [CODE_W-1:0] C_MCAST   = CODE_W'(1);
  localparam logic [CODE_W-1:0] C_UCAST   = CODE_W'(2);
  localparam logic [CODE_W-1:0] C_NULL    = CODE_W'(3);
  localparam logic [CODE_W-1:0] C_MGMT    = CODE_W'(4);
  localparam logic [CODE_W-1:0] C_CTRL    = CODE_W'(20);
  localparam logic [CODE_W-1:0] C_UNSUP   = CODE_W'(36);
  localparam logic [CODE_W-1:0] C_PHYERR  = CODE_W'(37);
  localparam logic [CODE_W-1:0] C_QNULL   = CODE_W'(38);
  localparam logic [CODE_W-1:0] C_QNULLTB = CODE_W'(39);

  localparam logic [1:0] T_MGMT = 2'd0;
  localparam logic [1:0] T_CTRL = 2'd1;
  localparam logic [1:0] T_DATA = 2'd2;

  localparam logic [3:0] ST_NULL  = 4'd4;
  localparam logic [3:0] ST_QNULL = 4'd12;

  logic [1:0] pver;
  logic [1:0] ftype;
  logic [3:0] subtype;
  logic [CODE_W-1:0] sub_ext;
  logic [CODE_W-1:0] next_code;

  assign pver    = frame_ctl[1:0];
  assign ftype   = frame_ctl[3:2];
  assign subtype = frame_ctl[7:4];
  assign sub_ext = CODE_W'(subtype);

  always_comb begin
    if (phy_err)
      next_code = C_PHYERR;
    else if (ndp)
      next_code = C_NDP;
    else if (pver != 2'd0 || ftype == 2'd3)
      next_code = C_UNSUP;
    else if (ftype == T_MGMT)
      next_code = C_MGMT + sub_ext;
    else if (ftype == T_CTRL)
      next_code = C_CTRL + sub_ext;
    else if (ftype == T_DATA && subtype == ST_NULL)
      next_code = C_NULL;
    else if (subtype == ST_QNULL)
      next_code = tb_ppdu ? C_QNULLTB : C_QNULL;
    else
      next_code = ra_group ? C_MCAST : C_UCAST;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_valid <= 1'b0;
      grp_code  <= '0;
    end else begin
      grp_valid <= hdr_valid;
      if (hdr_valid)
        grp_code <= next_code;
    end
  end
endmodule

module rx_frame_grouper_chk #(
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hdr_valid,
  input logic              ndp,
  input logic              phy_err,
  input logic              grp_valid,
  input logic [CODE_W-1:0] grp_code
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (grp_valid == $past(hdr_valid)));

  p_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> (grp_code <= CODE_W'(39)));

  p_phy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(hdr_valid && phy_err)) |-> (grp_code == CODE_W'(37)));

  p_ndp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(hdr_valid && ndp && !phy_err)) |-> (grp_code == CODE_W'(0)));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(hdr_valid)) |-> $stable(grp_code));
endmodule

bind rx_frame_grouper rx_frame_grouper_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .ndp(ndp),
  .phy_err(phy_err), .grp_valid(grp_valid), .grp_code(grp_code)
);

// File: tb/rx_frame_grouper_tb.sv
module rx_frame_grouper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0;
  logic [15:0] frame_ctl = '0;
  logic        ra_group = 1'b0;
  logic        ndp = 1'b0;
  logic        phy_err = 1'b0;
  logic        tb_ppdu = 1'b0;
  logic        grp_valid;
  logic [6:0]  grp_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_frame_grouper u_dut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .frame_ctl(frame_ctl),
    .ra_group(ra_group), .ndp(ndp), .phy_err(phy_err), .tb_ppdu(tb_ppdu),
    .grp_valid(grp_valid), .grp_code(grp_code)
  );

  // row: {phy_err, ndp, tb_ppdu, ra_group, frame_ctl[15:0], expected[6:0]}
  localparam int NV = 21;
  localparam logic [26:0] VEC [NV] = '{
    {4'b1000, 16'h0008, 7'd37},  // R3 phy error on data
    {4'b1100, 16'h0000, 7'd37},  // R3 phy error beats ndp
    {4'b0100, 16'h0008, 7'd0},   // R4 ndp
    {4'b0100, 16'h000C, 7'd0},   // R4 ndp beats reserved type
    {4'b0000, 16'h000C, 7'd36},  // R5 type 3
    {4'b0000, 16'h0001, 7'd36},  // R5 version 1 on mgmt
    {4'b0000, 16'h0000, 7'd4},   // R6 mgmt sub 0
    {4'b0000, 16'h00F0, 7'd19},  // R6 mgmt sub 15
    {4'b0000, 16'h0080, 7'd12},  // R6 mgmt sub 8
    {4'b0000, 16'h0004, 7'd20},  // R7 ctrl sub 0
    {4'b0000, 16'h00F4, 7'd35},  // R7 ctrl sub 15
    {4'b0000, 16'h00B4, 7'd31},  // R7 ctrl sub 11
    {4'b0001, 16'h0008, 7'd1},   // R10 multicast data
    {4'b0000, 16'h0008, 7'd2},   // R10 unicast data
    {4'b0001, 16'h0088, 7'd1},   // R10 qos data multicast
    {4'b0001, 16'h0048, 7'd3},   // R8 data null
    {4'b0000, 16'h00C8, 7'd38},  // R9 qos null
    {4'b0010, 16'h00C8, 7'd39},  // R9 qos null trigger-based
    {4'b0010, 16'h0008, 7'd2},   // R10 tb_ppdu no effect
    {4'b0000, 16'hFF08, 7'd2},   // R2 upper bits ignored
    {4'b0000, 16'h0049, 7'd36}   // R5 version 1 on null
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", grp_valid, 0);
    check("R1 reset code", grp_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle valid", grp_valid, 0);

    for (int i = 0; i < NV; i++) begin
      {phy_err, ndp, tb_ppdu, ra_group} = VEC[i][26:23];
      frame_ctl = VEC[i][22:7];
      hdr_valid = 1'b1;
      @(negedge clk);
      hdr_valid = 1'b0;
      check($sformatf("R1 vector %0d valid", i), grp_valid, 1);
      check($sformatf("R2-tagged vector %0d code", i), grp_code, int'(VEC[i][6:0]));
    end

    // R11 hold while idle, inputs changing
    frame_ctl = 16'h00F4; phy_err = 1'b1;
    @(negedge clk);
    check("R1 strobe drops", grp_valid, 0);
    check("R11 code holds", grp_code, 36);
    @(negedge clk);
    check("R11 code holds again", grp_code, 36);
    phy_err = 1'b0;

    // back-to-back strobes
    frame_ctl = 16'h0050; hdr_valid = 1'b1;
    @(negedge clk);
    check("R6 back-to-back first", grp_code, 9);
    frame_ctl = 16'h0054;
    @(negedge clk);
    check("R7 back-to-back second", grp_code, 25);
    check("R1 back-to-back valid", grp_valid, 1);

    // reset mid-stream
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears valid", grp_valid, 0);
    check("R1 reset clears code", grp_code, 0);
    hdr_valid = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset idle", grp_valid, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule